// File: doc/BRIEF.md
# Packet Stream Protocol Monitor

This block watches a 32-bit valid/ready packet stream from the side and never drives it. The stream carries valid, ready, a start marker, an end marker, a 2-bit empty count and a 32-bit data word. A beat is taken only in a cycle where the source asserts valid and the sink asserts ready (the sink may be ready in the same cycle valid rises). Once the source shows a beat with valid high and the sink holds ready low, the source must keep valid high and keep every beat field unchanged until the beat is taken. That is the back-pressure rule this monitor enforces.

The monitor judges framing only on accepted beats, so markers seen while valid is low, or while the beat is stalled, do not matter. A beat that starts and ends a packet at once is a complete packet. A new start may follow an end directly, with no idle cycle between them. Violations set sticky error bits that only a synchronous reset clears. They also raise a one-cycle error pulse. Two free-running 16-bit counters count accepted beats and accepted end beats, and a status pin shows whether a packet is open.

Top module: `stream_proto_monitor`

## Requirements
- R1: `beat_count` rises by one after every cycle with `mon_valid` and `mon_ready` both high. It stays put otherwise and wraps from 65535 to 0.
- R2: In a cycle with `mon_valid` low, `mon_sop`, `mon_eop`, `mon_empty` and `mon_data` change no state and raise no error, unless R8 applies.
- R3: `in_packet` goes high after an accepted beat with the start marker and without the end marker. It goes low after any accepted beat with the end marker. Otherwise it holds.
- R4: An accepted beat with both markers, taken while no packet is open, raises no error, leaves `in_packet` low and counts as one packet.
- R5: An accepted start beat in the cycle right after an accepted end beat is legal and raises no error.
- R6: An accepted beat without the start marker while `in_packet` is low sets `err_sticky[0]` (missing start). Such a beat does not open a packet.
- R7: An accepted beat with the start marker while `in_packet` is high sets `err_sticky[1]` (duplicate start). The packet stays open unless that beat also carries the end marker.
- R8: After a cycle with `mon_valid` high and `mon_ready` low, the next cycle must have `mon_valid` high and unchanged `mon_sop`, `mon_eop`, `mon_empty` and `mon_data`. Otherwise `err_sticky[2]` (hold violation) is set.
- R9: The value of `mon_empty` never raises an error on its own, on end beats or on any other beat.
- R10: `err_pulse` is high for the single cycle after a cycle that broke R6, R7 or R8. The matching sticky bit sets at that same edge, and sticky bits clear only on reset.
- R11: `pkt_count` rises by one after every accepted beat with the end marker and wraps from 65535 to 0.
- R12: While `rst` is high at a clock edge, all outputs clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_valid | input | 1 | Observed source valid |
| mon_ready | input | 1 | Observed sink ready |
| mon_sop | input | 1 | Observed start-of-packet marker |
| mon_eop | input | 1 | Observed end-of-packet marker |
| mon_empty | input | 2 | Observed empty symbol count |
| mon_data | input | 32 | Observed data word |
| err_sticky | output | 3 | Sticky errors: bit 0 missing start, bit 1 duplicate start, bit 2 hold violation |
| err_pulse | output | 1 | One-cycle error strobe |
| in_packet | output | 1 | A packet is open |
| beat_count | output | 16 | Accepted beats, wrapping |
| pkt_count | output | 16 | Accepted end beats, wrapping |

## Verification
The bound checker checks these on every cycle:
- both counters move only on accepted beats;
- sticky bits never fall;
- the pulse always has a sticky bit behind it;
- an idle cycle leaves the packet state alone;
- a lone one-beat packet leaves no packet open.

Only the bench's scenarios can show the rest: that each violation class sets the right bit, that legal single-beat and back-to-back framing stays silent, that empty and data are ignored where they should be, and that the counters wrap. It shows these by sweeping every pair of marker and handshake cycles after reset against an arithmetic model.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int ERR_W    = 3;
  localparam int ERR_MISS = 0;
  localparam int ERR_DUP  = 1;
  localparam int ERR_HOLD = 2;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/pmon_framing.sv
// Packet-open tracker and framing error detection on accepted beats.
module pmon_framing (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic sop,
  input  logic eop,
  output logic open_q,
  output logic miss_err,
  output logic dup_err
);
  logic open_d;

  always_comb begin
    miss_err = acc && !sop && !open_q;
    dup_err  = acc && sop && open_q;
    open_d   = open_q;
    if (acc) begin
      if (eop)      open_d = 1'b0;
      else if (sop) open_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= open_d;
  end
endmodule

// File: rtl/pmon_hold.sv
// Captures a stalled beat and flags any change before it is taken.
module pmon_hold #(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic               ready,
  input  logic               sop,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [DATA_W-1:0]  data,
  output logic               hold_err
);
  localparam int SIG_W = DATA_W + EMPTY_W + 2;

  logic [SIG_W-1:0] beat_now, beat_q;
  logic             stalled_q;

  assign beat_now = {sop, eop, empty, data};
  assign hold_err = stalled_q && (!valid || (beat_now != beat_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled_q <= 1'b0;
      beat_q    <= '0;
    end else begin
      stalled_q <= valid && !ready;
      beat_q    <= beat_now;
    end
  end
endmodule

// File: rtl/pmon_counters.sv
// Bank of wrapping event counters.
module pmon_counters #(
  parameter int CNT_W = 16,
  parameter int NUM   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM-1:0]             inc,
  output logic [NUM-1:0][CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stream_proto_monitor.sv
module stream_proto_monitor
  import pmon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_valid,
  input  logic               mon_ready,
  input  logic               mon_sop,
  input  logic               mon_eop,
  input  logic [EMPTY_W-1:0] mon_empty,
  input  logic [DATA_W-1:0]  mon_data,
  output logic [ERR_W-1:0]   err_sticky,
  output logic               err_pulse,
  output logic               in_packet,
  output logic [CNT_W-1:0]   beat_count,
  output logic [CNT_W-1:0]   pkt_count
);
  localparam int CNT_BEAT = 0;
  localparam int CNT_PKT  = 1;
  localparam int NUM_CNT  = 2;

  logic                          acc;
  logic                          miss_err, dup_err, hold_err;
  err_vec_t                      err_now;
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

  assign acc = mon_valid && mon_ready;

  pmon_framing u_framing (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .sop      (mon_sop),
    .eop      (mon_eop),
    .open_q   (in_packet),
    .miss_err (miss_err),
    .dup_err  (dup_err)
  );

  pmon_hold #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .valid    (mon_valid),
    .ready    (mon_ready),
    .sop      (mon_sop),
    .eop      (mon_eop),
    .empty    (mon_empty),
    .data     (mon_data),
    .hold_err (hold_err)
  );

  assign cnt_inc[CNT_BEAT] = acc;
  assign cnt_inc[CNT_PKT]  = acc && mon_eop;

  pmon_counters #(.CNT_W(CNT_W), .NUM(NUM_CNT)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (cnt_inc),
    .cnt (cnt_val)
  );

  assign beat_count = cnt_val[CNT_BEAT];
  assign pkt_count  = cnt_val[CNT_PKT];

  always_comb begin
    err_now           = '0;
    err_now[ERR_MISS] = miss_err;
    err_now[ERR_DUP]  = dup_err;
    err_now[ERR_HOLD] = hold_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_sticky <= '0;
      err_pulse  <= 1'b0;
    end else begin
      err_sticky <= err_sticky | err_now;
      err_pulse  <= |err_now;
    end
  end
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker #(
  parameter int EMPTY_W = 2,
  parameter int CNT_W   = 16,
  parameter int ERR_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               mon_valid,
  input logic               mon_ready,
  input logic               mon_sop,
  input logic               mon_eop,
  input logic [ERR_W-1:0]   err_sticky,
  input logic               err_pulse,
  input logic               in_packet,
  input logic [CNT_W-1:0]   beat_count,
  input logic [CNT_W-1:0]   pkt_count
);
  a_r1_beat_step: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && mon_ready) |=> beat_count == $past(beat_count) + CNT_W'(1));

  a_r1_beat_hold: assert property (@(posedge clk) disable iff (rst)
    !(mon_valid && mon_ready) |=> $stable(beat_count));

  a_r11_pkt_step: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && mon_ready && mon_eop) |=> pkt_count == $past(pkt_count) + CNT_W'(1));

  a_r11_pkt_hold: assert property (@(posedge clk) disable iff (rst)
    !(mon_valid && mon_ready && mon_eop) |=> $stable(pkt_count));

  a_r2_idle_state: assert property (@(posedge clk) disable iff (rst)
    !mon_valid |=> $stable(in_packet));

  a_r4_single_beat: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && mon_ready && mon_sop && mon_eop && !in_packet) |=> !in_packet);

  a_r10_sticky_keep: assert property (@(posedge clk) disable iff (rst)
    (|err_sticky) |=> (err_sticky & $past(err_sticky)) == $past(err_sticky));

  a_r10_pulse_bit: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (|err_sticky));
endmodule

bind stream_proto_monitor pmon_checker #(
  .EMPTY_W(EMPTY_W), .CNT_W(CNT_W), .ERR_W(pmon_pkg::ERR_W)
) u_pmon_checker (
  .clk        (clk),
  .rst        (rst),
  .mon_valid  (mon_valid),
  .mon_ready  (mon_ready),
  .mon_sop    (mon_sop),
  .mon_eop    (mon_eop),
  .err_sticky (err_sticky),
  .err_pulse  (err_pulse),
  .in_packet  (in_packet),
  .beat_count (beat_count),
  .pkt_count  (pkt_count)
);

// File: tb/test_stream_proto_monitor.sv
`timescale 1ns/1ps
module test_stream_proto_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 0, r = 0, s = 0, e = 0;
  logic [1:0]  em = 0;
  logic [31:0] d = 0;
  logic [2:0]  err_sticky;
  logic        err_pulse, in_packet;
  logic [15:0] beat_count, pkt_count;

  int checks = 0, failures = 0;
  logic        done = 1'b0;

  // reference model state
  logic        m_open, m_stall, m_pulse, m_ps, m_pe;
  logic [1:0]  m_pem;
  logic [31:0] m_pd;
  logic [2:0]  m_sticky;
  logic [15:0] m_beats, m_pkts;

  always #2.5 clk = ~clk;

  stream_proto_monitor i_stream_proto_monitor (
    .clk(clk), .rst(rst), .mon_valid(v), .mon_ready(r), .mon_sop(s),
    .mon_eop(e), .mon_empty(em), .mon_data(d), .err_sticky(err_sticky),
    .err_pulse(err_pulse), .in_packet(in_packet), .beat_count(beat_count),
    .pkt_count(pkt_count)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(in_packet == m_open, tag, "in_packet R3", in_packet, m_open);
    chk(beat_count == m_beats, tag, "beat_count R1", beat_count, m_beats);
    chk(pkt_count == m_pkts, tag, "pkt_count R11", pkt_count, m_pkts);
    chk(err_sticky == m_sticky, tag, "err_sticky R10", err_sticky, m_sticky);
    chk(err_pulse == m_pulse, tag, "err_pulse R10", err_pulse, m_pulse);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; v = 0; r = 0; s = 0; e = 0; em = 0; d = 0;
    @(posedge clk); @(posedge clk); #1;
    m_open = 0; m_stall = 0; m_pulse = 0; m_ps = 0; m_pe = 0; m_pem = 0;
    m_pd = 0; m_sticky = 0; m_beats = 0; m_pkts = 0;
    chk(err_sticky == 0 && !err_pulse && !in_packet && beat_count == 0 &&
        pkt_count == 0, "R12", "reset outputs", {err_sticky, err_pulse, in_packet}, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic step(input logic iv, ir, is, ie, input logic [1:0] iem,
                      input logic [31:0] id, input string tag, input bit cmp);
    logic acc, hold, miss, dup;
    @(negedge clk);
    v = iv; r = ir; s = is; e = ie; em = iem; d = id;
    acc  = iv && ir;
    hold = m_stall && (!iv || is != m_ps || ie != m_pe || iem != m_pem || id != m_pd);
    miss = acc && !is && !m_open;
    dup  = acc && is && m_open;
    m_pulse  = hold || miss || dup;
    m_sticky = m_sticky | {hold, dup, miss};
    if (acc) begin
      m_beats++;
      if (ie) begin m_pkts++; m_open = 0; end
      else if (is) m_open = 1;
    end
    m_stall = iv && !ir;
    m_ps = is; m_pe = ie; m_pem = iem; m_pd = id;
    @(posedge clk); #1;
    if (cmp) compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R4: lone single-beat packet
    step(1, 1, 1, 1, 2'd3, 32'hA5A5_0001, "R4", 1);
    chk(err_sticky == 0 && !in_packet && pkt_count == 1, "R4", "one-beat packet",
        {err_sticky, in_packet}, 0);

    // R5: back-to-back packets, no idle
    step(1, 1, 1, 0, 2'd1, 32'h1, "R5", 1);
    step(1, 1, 0, 1, 2'd2, 32'h2, "R5", 1);
    step(1, 1, 1, 0, 2'd0, 32'h3, "R5", 1);
    chk(err_sticky == 0 && in_packet, "R5", "start after end", err_sticky, 0);

    // R2: markers toggling with valid low
    step(0, 1, 1, 1, 2'd3, 32'hFFFF, "R2", 1);
    step(0, 0, 0, 1, 2'd1, 32'h0, "R2", 1);
    chk(in_packet && beat_count == 4 && err_sticky == 0, "R2", "idle ignored",
        beat_count, 4);

    // R9: empty varies on middle and end beats
    step(1, 1, 0, 0, 2'd3, 32'h10, "R9", 1);
    step(1, 1, 0, 0, 2'd2, 32'h11, "R9", 1);
    step(1, 1, 0, 1, 2'd1, 32'h12, "R9", 1);
    chk(err_sticky == 0 && !err_pulse, "R9", "empty no error", err_sticky, 0);

    // R8: legal stall then accept
    step(1, 0, 1, 0, 2'd2, 32'hBEEF, "R8", 1);
    step(1, 0, 1, 0, 2'd2, 32'hBEEF, "R8", 1);
    step(1, 1, 1, 0, 2'd2, 32'hBEEF, "R8", 1);
    chk(err_sticky == 0, "R8", "held stall legal", err_sticky, 0);

    // R6: missing start
    do_reset();
    step(1, 1, 0, 0, 2'd0, 32'h5, "R6", 1);
    chk(err_sticky == 3'b001 && err_pulse && !in_packet, "R6", "missing start",
        err_sticky, 1);
    step(0, 0, 0, 0, 2'd0, 32'h5, "R10", 1);
    chk(!err_pulse && err_sticky == 3'b001, "R10", "pulse one cycle, bit sticks",
        err_pulse, 0);
    repeat (5) step(1, 1, 1, 1, 2'd0, 32'h6, "R10", 1);
    chk(err_sticky == 3'b001, "R10", "sticky persists", err_sticky, 1);

    // R7: duplicate start
    do_reset();
    step(1, 1, 1, 0, 2'd0, 32'h7, "R7", 1);
    step(1, 1, 1, 0, 2'd0, 32'h8, "R7", 1);
    chk(err_sticky == 3'b010 && in_packet, "R7", "duplicate start", err_sticky, 2);

    // R8: data change while stalled, then valid drop while stalled
    do_reset();
    step(1, 0, 1, 0, 2'd0, 32'h9, "R8", 1);
    step(1, 0, 1, 0, 2'd0, 32'hA, "R8", 1);
    chk(err_sticky == 3'b100 && err_pulse, "R8", "data changed in stall", err_sticky, 4);
    do_reset();
    step(1, 0, 1, 0, 2'd1, 32'h9, "R8", 1);
    step(0, 0, 1, 0, 2'd1, 32'h9, "R8", 1);
    chk(err_sticky == 3'b100, "R8", "valid dropped in stall", err_sticky, 4);
    do_reset();
    step(1, 0, 1, 0, 2'd1, 32'h9, "R8", 1);
    step(1, 1, 1, 0, 2'd2, 32'h9, "R8", 1);
    chk(err_sticky == 3'b100, "R8", "empty changed in stall", err_sticky, 4);

    // R3: exhaustive pairs of {valid,ready,sop,eop}
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        step(a[3], a[2], a[1], a[0], 2'(a), 32'h77, "R3", 1);
        step(b[3], b[2], b[1], b[0], 2'(b), 32'h77, "R3", 1);
      end
    end

    // R1 and R11: wrap of both counters
    do_reset();
    for (int i = 0; i < 65535; i++) step(1, 1, 1, 1, 2'(i), 32'(i), "R1", 0);
    chk(beat_count == 16'hFFFF && pkt_count == 16'hFFFF, "R1", "before wrap",
        beat_count, 16'hFFFF);
    step(1, 1, 1, 1, 2'd0, 32'h0, "R11", 1);
    chk(beat_count == 0 && pkt_count == 0, "R11", "wrap to zero", pkt_count, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule